// File: doc/BRIEF.md
# Keyed Write Protection Gate

This block stands between the host write path and a page-write controller. Every qualified write (one cycle with `wr_valid` high) is classified in the same cycle: either it may be stored in the array (`wr_permit`), or it is one byte of a key sequence and must be dropped (`cmd_flag`), or it is refused. A protection flag, cleared by reset and standing in for a nonvolatile bit, decides whether ordinary writes pass freely.

A three-write key both sets the flag and opens a single page window. That window accepts up to `PAGE_BYTES` bytes on one page and closes when it is full or when the host stops loading for `LOAD_TIMEOUT` cycles. After it closes the block is protected again. A six-write key starts a clear that takes `DIS_CYCLES` cycles. During that clear every write is ignored, and once it ends the flag drops. The top address bit takes no part in key matching.

Top module: `cmd_write_guard`

## Requirements
- R1: Reset clears the protection flag (`prot_on`=0). With the flag clear, a write that is not a key byte gets `wr_permit`=1 and `cmd_flag`=0 in the same cycle.
- R2: The enable key is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. `prot_on` is 1 from the cycle after the third write.
- R3: A write that matches the next expected key step drives `cmd_flag`=1 and `wr_permit`=0 in the same cycle, whether or not protection is on.
- R4: Once the enable key completes, the page window is open. The first accepted byte fixes the page, which is address bits [ADDR_W-1:log2(PAGE_BYTES)]. A later write to another page is refused, is not counted, and does not restart the idle timer.
- R5: The window closes after `PAGE_BYTES` accepted writes. The next write is refused.
- R6: The window closes when `LOAD_TIMEOUT` consecutive cycles pass without an accepted write, counted from the opening or from the last accepted write.
- R7: While protected with no window open and no clear in progress, a write that is not a key byte gives `wr_permit`=0 and `cmd_flag`=0.
- R8: A write that breaks a partial key returns matching to the start. If that write is itself 0xAA at 0x5555, it counts as the first key step (`cmd_flag`=1). Otherwise it is refused when protected and permitted when unprotected.
- R9: The disable key is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. For the next `DIS_CYCLES` cycles all writes give both outputs 0. `prot_on` then falls, and ordinary writes are permitted.
- R10: Issuing the enable key while already protected opens a fresh window, and `prot_on` stays 1.
- R11: Address bit ADDR_W-1 is ignored when matching keys, so 0xD555 matches 0x5555.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the protection flag |
| wr_valid | input | 1 | One qualified write this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_permit | output | 1 | This write may be stored in the array |
| cmd_flag | output | 1 | This write is a key byte and must not be stored |
| prot_on | output | 1 | Protection flag |

## Verification
The hardest state to reach is a broken key that lands on the first key byte while protection is already on. The block must restart matching there instead of aborting, and must then accept a full enable key that reopens a window. The stimulus first arms protection and fills a page. It then interrupts a partial key with an ordinary byte, repeats 0xAA@0x5555 twice, and completes the key. After that it lets the window expire through idle cycles and finally runs the disable key with writes pushed into the clearing interval. A behavioural model in the bench predicts all three outputs on every clock.

// File: rtl/cmd_write_guard.sv
module cmd_write_guard #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 128,
  parameter int LOAD_TIMEOUT = 5000,
  parameter int DIS_CYCLES   = 500000,
  parameter logic [15:0] KEY_A = 16'h5555,
  parameter logic [15:0] KEY_B = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_permit,
  output logic              cmd_flag,
  output logic              prot_on
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int KEY_W  = ADDR_W - 1;
  localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
  localparam int IDLE_W = $clog2(LOAD_TIMEOUT + 1);
  localparam int DIS_W  = $clog2(DIS_CYCLES + 1);
  localparam logic [DATA_W-1:0] D_K1  = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] D_K2  = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] D_ARM = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] D_DIS = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] D_OFF = DATA_W'(8'h20);

  logic [2:0]        step;
  logic              prot, win_open, win_used, dis_busy;
  logic [CNT_W-1:0]  win_cnt;
  logic [PG_W-1:0]   win_page;
  logic [IDLE_W-1:0] idle_cnt;
  logic [DIS_W-1:0]  dis_cnt;

  wire at_a   = wr_addr[KEY_W-1:0] == KEY_A[KEY_W-1:0];
  wire at_b   = wr_addr[KEY_W-1:0] == KEY_B[KEY_W-1:0];
  wire is_k1  = at_a && wr_data == D_K1;
  wire is_k2  = at_b && wr_data == D_K2;
  wire is_arm = at_a && wr_data == D_ARM;
  wire is_dis = at_a && wr_data == D_DIS;
  wire is_off = at_a && wr_data == D_OFF;

  logic step_hit;
  always_comb begin
    case (step)
      3'd0, 3'd3: step_hit = is_k1;
      3'd1, 3'd4: step_hit = is_k2;
      3'd2:       step_hit = is_arm || is_dis;
      3'd5:       step_hit = is_off;
      default:    step_hit = 1'b0;
    endcase
  end

  wire match_on    = wr_valid && !dis_busy && !win_open;
  wire key_hit     = match_on && step_hit;
  wire key_restart = match_on && !step_hit && is_k1;
  wire arm_now     = key_hit && step == 3'd2 && is_arm;
  wire off_now     = key_hit && step == 3'd5;
  wire page_ok     = !win_used || wr_addr[ADDR_W-1:OFF_W] == win_page;
  wire win_take    = wr_valid && win_open && page_ok;
  wire dis_last    = dis_busy && dis_cnt == DIS_W'(DIS_CYCLES - 1);

  assign cmd_flag  = key_hit || key_restart;
  assign wr_permit = win_take || (match_on && !cmd_flag && !prot);
  assign prot_on   = prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= 3'd0;
    end else if (key_hit) begin
      if (step == 3'd2)      step <= is_arm ? 3'd0 : 3'd3;
      else if (step == 3'd5) step <= 3'd0;
      else                   step <= step + 3'd1;
    end else if (key_restart) begin
      step <= 3'd1;
    end else if (match_on) begin
      step <= 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prot <= 1'b0;
    else if (arm_now)  prot <= 1'b1;
    else if (dis_last) prot <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      win_used <= 1'b0;
      win_cnt  <= '0;
      win_page <= '0;
      idle_cnt <= '0;
    end else if (arm_now) begin
      win_open <= 1'b1;
      win_used <= 1'b0;
      win_cnt  <= '0;
      idle_cnt <= '0;
    end else if (win_open) begin
      if (win_take) begin
        win_used <= 1'b1;
        win_page <= wr_addr[ADDR_W-1:OFF_W];
        win_cnt  <= win_cnt + CNT_W'(1);
        idle_cnt <= '0;
        if (win_cnt == CNT_W'(PAGE_BYTES - 1)) win_open <= 1'b0;
      end else if (idle_cnt == IDLE_W'(LOAD_TIMEOUT - 1)) begin
        win_open <= 1'b0;
      end else begin
        idle_cnt <= idle_cnt + IDLE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_busy <= 1'b0;
      dis_cnt  <= '0;
    end else if (off_now) begin
      dis_busy <= 1'b1;
      dis_cnt  <= '0;
    end else if (dis_busy) begin
      if (dis_last) dis_busy <= 1'b0;
      else          dis_cnt  <= dis_cnt + DIS_W'(1);
    end
  end
endmodule

module cmd_write_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_permit,
  input logic cmd_flag,
  input logic prot_on,
  input logic win_open,
  input logic dis_busy
);
  a_r3_cmd_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flag |-> !wr_permit);
  a_r1_out_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_permit || cmd_flag) |-> wr_valid);
  a_r9_clear_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    dis_busy |-> (!wr_permit && !cmd_flag));
  a_r2_rise_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(cmd_flag));
  a_r9_fall_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(dis_busy));
  a_r4_window_protected: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> prot_on);
endmodule

bind cmd_write_guard cmd_write_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_permit(wr_permit),
  .cmd_flag(cmd_flag), .prot_on(prot_on), .win_open(win_open), .dis_busy(dis_busy)
);

// File: tb/cmd_write_guard_tb.sv
module cmd_write_guard_tb;
  localparam int PB = 4, TO = 8, DC = 6;
  logic clk = 0, rst_n = 0, wr_valid = 0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_permit, cmd_flag, prot_on;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cmd_write_guard #(.PAGE_BYTES(PB), .LOAD_TIMEOUT(TO), .DIS_CYCLES(DC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_permit(wr_permit), .cmd_flag(cmd_flag), .prot_on(prot_on));

  int m_step, m_cnt, m_page, m_idle, m_dcnt;
  bit m_prot, m_win, m_used, m_busy;

  task automatic model_clear();
    m_step = 0; m_cnt = 0; m_page = 0; m_idle = 0; m_dcnt = 0;
    m_prot = 0; m_win = 0; m_used = 0; m_busy = 0;
  endtask

  task automatic cmp(input string tag, input string what, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [15:0] a, input logic [7:0] d, input string tag);
    bit lo, hi, hit, rst1, act, ecmd, eperm, take;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d;
    #1;
    lo = a[14:0] == 15'h5555;
    hi = a[14:0] == 15'h2AAA;
    case (m_step)
      0, 3: hit = lo && d == 8'hAA;
      1, 4: hit = hi && d == 8'h55;
      2:    hit = lo && (d == 8'hA0 || d == 8'h80);
      default: hit = lo && d == 8'h20;
    endcase
    act  = v && !m_busy && !m_win;
    rst1 = !hit && lo && d == 8'hAA;
    ecmd = act && (hit || rst1);
    take = v && m_win && (!m_used || int'(a[15:2]) == m_page);
    eperm = take || (act && !ecmd && !m_prot);
    cmp(tag, "wr_permit", wr_permit, eperm);
    cmp(tag, "cmd_flag", cmd_flag, ecmd);
    cmp(tag, "prot_on", prot_on, m_prot);
    if (m_busy) begin
      if (m_dcnt == DC - 1) begin m_busy = 0; m_prot = 0; end
      else m_dcnt++;
    end else if (m_win) begin
      if (take) begin
        m_used = 1; m_page = int'(a[15:2]); m_cnt++; m_idle = 0;
        if (m_cnt == PB) m_win = 0;
      end else if (m_idle == TO - 1) m_win = 0;
      else m_idle++;
    end else if (act) begin
      if (hit && m_step == 2 && d == 8'hA0) begin
        m_step = 0; m_prot = 1; m_win = 1; m_used = 0; m_cnt = 0; m_idle = 0;
      end else if (hit && m_step == 5) begin
        m_step = 0; m_busy = 1; m_dcnt = 0;
      end else if (hit) m_step = (m_step == 2) ? 3 : m_step + 1;
      else if (rst1) m_step = 1;
      else m_step = 0;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, 8'h0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_valid = 0;
    @(negedge clk);
    model_clear();
    rst_n = 1;
  endtask

  task automatic enable_key(input logic [15:0] hi_bit, input string tag);
    cyc(1, 16'h5555 | hi_bit, 8'hAA, tag);
    cyc(1, 16'h2AAA | hi_bit, 8'h55, tag);
    cyc(1, 16'h5555 | hi_bit, 8'hA0, tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    idle(2, "R1");
    cyc(1, 16'h0100, 8'h11, "R1");
    cyc(1, 16'h0101, 8'h22, "R1");
    // R11: key with the top address bit set, R2/R3 flags and flag rise
    enable_key(16'h8000, "R11");
    // R4: page locks on first byte; other page refused
    cyc(1, 16'h1000, 8'h01, "R4");
    cyc(1, 16'h2000, 8'h02, "R4");
    cyc(1, 16'h1001, 8'h03, "R4");
    cyc(1, 16'h1002, 8'h04, "R4");
    cyc(1, 16'h1003, 8'h05, "R5");
    cyc(1, 16'h1000, 8'h06, "R5");
    // R7: protected, no window
    cyc(1, 16'h0300, 8'h07, "R7");
    idle(1, "R7");
    // R8: broken key while protected, then restart on first key byte
    cyc(1, 16'h5555, 8'hAA, "R3");
    cyc(1, 16'h0400, 8'h12, "R8");
    cyc(1, 16'h5555, 8'hAA, "R8");
    cyc(1, 16'h5555, 8'hAA, "R8");
    cyc(1, 16'h2AAA, 8'h55, "R10");
    cyc(1, 16'h5555, 8'hA0, "R10");
    // R6: one byte then idle timeout
    cyc(1, 16'h3004, 8'h21, "R6");
    idle(TO + 1, "R6");
    cyc(1, 16'h3005, 8'h22, "R6");
    // R9: disable key, writes during clear ignored
    cyc(1, 16'h5555, 8'hAA, "R9");
    cyc(1, 16'h2AAA, 8'h55, "R9");
    cyc(1, 16'h5555, 8'h80, "R9");
    cyc(1, 16'h5555, 8'hAA, "R9");
    cyc(1, 16'h2AAA, 8'h55, "R9");
    cyc(1, 16'h5555, 8'h20, "R9");
    cyc(1, 16'h0600, 8'h31, "R9");
    cyc(1, 16'h5555, 8'hAA, "R9");
    idle(DC, "R9");
    cyc(1, 16'h0601, 8'h32, "R9");
    // R8: broken key while unprotected permits the breaking write
    cyc(1, 16'h5555, 8'hAA, "R8");
    cyc(1, 16'h2AAA, 8'h55, "R8");
    cyc(1, 16'h0500, 8'h33, "R8");
    // R1: reset after arming clears the flag
    enable_key(16'h0000, "R2");
    idle(2, "R2");
    do_reset();
    idle(1, "R1");
    cyc(1, 16'h0700, 8'h44, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule